// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a 2 KB data cache that sits between a processor's load/store port and a word-wide main memory. It holds 128 lines of four 32-bit words, and each line has a 21-bit tag, a valid bit and a dirty bit. A store that hits changes only the cached copy and marks the line dirty. A modified line goes back to memory only when another address that maps to the same line evicts it. A miss on either a load or a store allocates the line.

Two state machines run the cache. An access machine looks up every request. It finishes a hit in the same cycle. On a miss it latches the request, starts a fill machine, and then waits on the fill machine's busy flag. The fill machine first copies the victim line out, one word per memory handshake, but only when that line is valid and dirty. It then reads the new line, one word per handshake. While the fill runs, the processor sees a busy signal. The processor holds its request until it sees the acknowledge pulse.

Top module: `dcache_wb`

## Requirements
- R1: After reset every line is invalid, so the first access to any line misses. While reset is active and just after it, `cpu_ack_o`, `cpu_busy_o` and `mem_req_o` are low.
- R2: Address bits [10:4] select the line, bits [3:2] select the word and bits [31:11] form the tag. Each memory transfer uses the address {tag, line, word, 2'b00}.
- R3: A read that hits raises `cpu_ack_o` in the cycle the request is presented, with the addressed word on `cpu_rdata_o`, `cpu_busy_o` low and no memory request.
- R4: A write that hits updates the cached word in that same cycle and issues no memory transfer. Later reads return the new value.
- R5: A read miss issues four memory reads of the new line in word order 0,1,2,3. It then acknowledges with the requested word and leaves the line clean.
- R6: A write miss first refills the line as in R5. It then merges the written word into the line and marks the line dirty, so that a later eviction writes the new value back.
- R7: When the victim line is valid and dirty, four memory writes come before the refill. They go in word order 0..3, use the victim's stored tag in the address, and carry the cached data.
- R8: Each memory transfer holds `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` steady until a cycle in which `mem_ready_i` is high. The fill advances exactly one word per such cycle.
- R9: On a miss, `cpu_busy_o` is high from the request cycle until the completion cycle. `cpu_ack_o` is a one-cycle pulse that never coincides with busy or with a memory request.
- R10: A victim that is valid but clean is replaced without any memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Access request, held until acknowledged |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Write data |
| cpu_rdata_o | output | 32 | Read data, valid with acknowledge |
| cpu_ack_o | output | 1 | Access complete |
| cpu_busy_o | output | 1 | Miss in progress, processor must stall |
| mem_req_o | output | 1 | Memory word transfer request |
| mem_we_o | output | 1 | 1 = write-back word, 0 = refill read |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_rdata_i | input | 32 | Refill data |
| mem_ready_i | input | 1 | Memory accepts or returns the current word |

## Verification
The hardest case to reach is an eviction of a dirty line while memory inserts wait states. The eight transfers must stay ordered, and every address must carry the old tag, not the requesting one. The stimulus sweeps writes and reads across three tags, chosen to include an all-ones tag, that compete for a handful of lines at both ends of the index range. This produces dirty evictions, clean evictions and fills into invalid lines in a mix. The memory model varies its latency by word position. A reference model of tags, valid and dirty bits and line data predicts the exact transfer list and return data for every access.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned LINE_WORDS = 4;
  localparam int unsigned OFF_W      = $clog2(LINE_WORDS);

  typedef enum logic [1:0] {ACC_IDLE, ACC_RD, ACC_WR} acc_state_e;

  // write-back states directly precede refill states; order is relied upon
  typedef enum logic [3:0] {
    FL_IDLE, FL_START,
    FL_WB0, FL_WB1, FL_WB2, FL_WB3,
    FL_RF0, FL_RF1, FL_RF2, FL_RF3
  } fill_state_e;
endpackage

// File: rtl/dc_store.sv
module dc_store
  import dc_pkg::*;
#(
  parameter int unsigned LINES = 128,
  parameter int unsigned IDX_W = $clog2(LINES),
  parameter int unsigned TAG_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OFF_W-1:0]  a_word_i,
  output logic [WORD_W-1:0] a_data_o,
  input  logic [OFF_W-1:0]  b_word_i,
  output logic [WORD_W-1:0] b_data_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              valid_o,
  output logic              dirty_o,
  input  logic              wd_en_i,
  input  logic [OFF_W-1:0]  wd_word_i,
  input  logic [WORD_W-1:0] wd_data_i,
  input  logic              meta_we_i,
  input  logic [TAG_W-1:0]  meta_tag_i,
  input  logic              set_dirty_i
);
  localparam int unsigned ENTRIES = LINES * LINE_WORDS;

  logic [WORD_W-1:0] data_q [ENTRIES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q, dirty_q;

  always_ff @(posedge clk_i) begin
    if (wd_en_i) data_q[{idx_i, wd_word_i}] <= wd_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (meta_we_i) tag_q[idx_i] <= meta_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (meta_we_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (set_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  assign a_data_o = data_q[{idx_i, a_word_i}];
  assign b_data_o = data_q[{idx_i, b_word_i}];
  assign tag_o    = tag_q[idx_i];
  assign valid_o  = valid_q[idx_i];
  assign dirty_o  = dirty_q[idx_i];
endmodule

// File: rtl/dc_access_fsm.sv
module dc_access_fsm
  import dc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              hit_i,
  input  logic              fill_busy_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              go_o,
  output logic              ack_o,
  output logic              busy_o,
  output logic              wr_en_o
);
  acc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  wire idle = (state_q == ACC_IDLE);
  assign addr_o    = idle ? addr_i  : addr_q;
  assign wr_data_o = idle ? wdata_i : wdata_q;

  always_comb begin
    state_d = state_q;
    go_o    = 1'b0;
    ack_o   = 1'b0;
    busy_o  = 1'b0;
    wr_en_o = 1'b0;
    unique case (state_q)
      ACC_IDLE: if (req_i) begin
        if (hit_i) begin
          ack_o   = 1'b1;
          wr_en_o = we_i;
        end else begin
          go_o    = 1'b1;
          busy_o  = 1'b1;
          state_d = we_i ? ACC_WR : ACC_RD;
        end
      end
      ACC_RD, ACC_WR: if (fill_busy_i) begin
        busy_o = 1'b1;
      end else begin
        ack_o   = 1'b1;
        wr_en_o = (state_q == ACC_WR);
        state_d = ACC_IDLE;
      end
      default: state_d = ACC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACC_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (go_o) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/dc_fill_fsm.sv
module dc_fill_fsm
  import dc_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned TAG_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [TAG_W-1:0]  vic_tag_i,
  input  logic              vic_valid_i,
  input  logic              vic_dirty_i,
  input  logic [WORD_W-1:0] line_word_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic [OFF_W-1:0]  word_o,
  output logic              wd_en_o,
  output logic              meta_we_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o
);
  fill_state_e state_q, state_d;
  logic [3:0]  rel;
  logic        in_wb, in_rf;

  assign in_wb  = (state_q >= FL_WB0) && (state_q <= FL_WB3);
  assign in_rf  = (state_q >= FL_RF0) && (state_q <= FL_RF3);
  // offset from FL_WB0; low bits give the word in both phases
  assign rel    = 4'(state_q - FL_WB0);
  assign word_o = rel[OFF_W-1:0];
  assign busy_o = (state_q != FL_IDLE);

  assign mem_req_o   = in_wb || in_rf;
  assign mem_we_o    = in_wb;
  assign mem_addr_o  = {(in_wb ? vic_tag_i : req_tag_i), idx_i, word_o, 2'b00};
  assign mem_wdata_o = line_word_i;
  assign wd_en_o     = in_rf && mem_ready_i;
  assign meta_we_o   = (state_q == FL_RF3) && mem_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FL_IDLE:  if (go_i) state_d = FL_START;
      FL_START: state_d = (vic_valid_i && vic_dirty_i) ? FL_WB0 : FL_RF0;
      FL_RF3:   if (mem_ready_i) state_d = FL_IDLE;
      default:  if (mem_ready_i) state_d = fill_state_e'(state_q + 4'd1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FL_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import dc_pkg::*;
#(
  parameter int unsigned LINES = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cpu_req_i,
  input  logic        cpu_we_i,
  input  logic [31:0] cpu_addr_i,
  input  logic [31:0] cpu_wdata_i,
  output logic [31:0] cpu_rdata_o,
  output logic        cpu_ack_o,
  output logic        cpu_busy_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_ready_i
);
  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned IDX_LO = OFF_W + 2;
  localparam int unsigned TAG_LO = IDX_LO + IDX_W;
  localparam int unsigned TAG_W  = ADDR_W - TAG_LO;

  logic [ADDR_W-1:0] addr_cur;
  logic [WORD_W-1:0] acc_wdata, b_data;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag_cur, tag_st;
  logic [OFF_W-1:0]  cpu_word, fill_word;
  logic valid_st, dirty_st, hit, go, acc_wr, fill_busy, fill_wd, meta_we;
  logic unused_low;

  assign idx        = addr_cur[TAG_LO-1:IDX_LO];
  assign tag_cur    = addr_cur[ADDR_W-1:TAG_LO];
  assign cpu_word   = addr_cur[IDX_LO-1:2];
  assign unused_low = ^addr_cur[1:0];
  assign hit        = valid_st && (tag_st == tag_cur);

  dc_access_fsm i_access (
    .clk_i, .rst_ni,
    .req_i(cpu_req_i), .we_i(cpu_we_i), .addr_i(cpu_addr_i), .wdata_i(cpu_wdata_i),
    .hit_i(hit), .fill_busy_i(fill_busy),
    .addr_o(addr_cur), .wr_data_o(acc_wdata), .go_o(go),
    .ack_o(cpu_ack_o), .busy_o(cpu_busy_o), .wr_en_o(acc_wr)
  );

  dc_fill_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_fill (
    .clk_i, .rst_ni,
    .go_i(go), .idx_i(idx), .req_tag_i(tag_cur), .vic_tag_i(tag_st),
    .vic_valid_i(valid_st), .vic_dirty_i(dirty_st), .line_word_i(b_data),
    .mem_ready_i, .busy_o(fill_busy), .word_o(fill_word),
    .wd_en_o(fill_wd), .meta_we_o(meta_we),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o
  );

  dc_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_store (
    .clk_i, .rst_ni,
    .idx_i(idx),
    .a_word_i(cpu_word), .a_data_o(cpu_rdata_o),
    .b_word_i(fill_word), .b_data_o(b_data),
    .tag_o(tag_st), .valid_o(valid_st), .dirty_o(dirty_st),
    .wd_en_i(fill_wd || acc_wr),
    .wd_word_i(fill_wd ? fill_word : cpu_word),
    .wd_data_i(fill_wd ? mem_rdata_i : acc_wdata),
    .meta_we_i(meta_we), .meta_tag_i(tag_cur),
    .set_dirty_i(acc_wr)
  );
endmodule

// File: rtl/dc_checker.sv
module dc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cpu_req_i,
  input logic        cpu_ack_o,
  input logic        cpu_busy_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ready_i
);
  assert_ack_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> !cpu_busy_o);
  assert_ack_needs_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> cpu_req_i);
  assert_ack_no_mem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> !mem_req_o);
  assert_mem_stalls_cpu_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> cpu_busy_o);
  assert_hold_until_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  assert_wdata_steady_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_ready_i) |=> $stable(mem_wdata_o));
  assert_refill_after_wb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ready_i && (mem_addr_o[3:2] == 2'd3)) |=> (mem_req_o && !mem_we_o));
  assert_word_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
endmodule

bind dcache_wb dc_checker i_dc_checker (
  .clk_i, .rst_ni, .cpu_req_i, .cpu_ack_o, .cpu_busy_o,
  .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ready_i
);

// File: tb/test_dcache_wb.sv
module test_dcache_wb;
  localparam int LINES = 128;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } xact_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [31:0] cpu_addr_i = '0, cpu_wdata_i = '0;
  logic [31:0] cpu_rdata_o;
  logic        cpu_ack_o, cpu_busy_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ready_i = 1'b0;

  always #5 clk_i = ~clk_i;

  dcache_wb #(.LINES(LINES)) i_dcache_wb (
    .clk_i, .rst_ni, .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_rdata_o, .cpu_ack_o, .cpu_busy_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ready_i
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // memory environment
  logic [31:0] mem_wr [logic [31:0]];
  function automatic logic [31:0] mem_rd(logic [31:0] a);
    if (mem_wr.exists(a)) return mem_wr[a];
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  int wait_cnt = 0;
  always @(negedge clk_i) begin
    if (mem_ready_i) begin
      mem_ready_i = 1'b0;
      wait_cnt    = 0;
    end else if (mem_req_o) begin
      if (wait_cnt >= int'(mem_addr_o[3:2]) % 3) begin
        mem_ready_i = 1'b1;
        mem_rdata_i = mem_rd(mem_addr_o);
      end else begin
        wait_cnt++;
      end
    end
  end

  xact_t log_q[$];
  always @(posedge clk_i) begin
    if (rst_ni && mem_req_o && mem_ready_i) begin
      log_q.push_back({mem_we_o, mem_addr_o, mem_we_o ? mem_wdata_o : mem_rdata_i});
      if (mem_we_o) mem_wr[mem_addr_o] = mem_wdata_o;
    end
  end

  // reference model
  bit          mv [LINES];
  bit          md [LINES];
  logic [20:0] mt [LINES];
  logic [31:0] mdat [LINES][4];

  task automatic access(bit we, logic [31:0] addr, logic [31:0] wd);
    xact_t       exp_q[$];
    logic [6:0]  idx;
    logic [1:0]  w;
    logic [20:0] tg;
    logic [31:0] exp_rd;
    bit          hit, wb;
    int          cyc;
    idx = addr[10:4];
    w   = addr[3:2];
    tg  = addr[31:11];
    hit = mv[idx] && (mt[idx] == tg);
    wb  = !hit && mv[idx] && md[idx];
    if (!hit) begin
      if (wb)
        for (int k = 0; k < 4; k++)
          exp_q.push_back({1'b1, mt[idx], idx, 2'(k), 2'b00, mdat[idx][k]});
      for (int k = 0; k < 4; k++) begin
        exp_q.push_back({1'b0, tg, idx, 2'(k), 2'b00, mem_rd({tg, idx, 2'(k), 2'b00})});
        mdat[idx][k] = mem_rd({tg, idx, 2'(k), 2'b00});
      end
      mt[idx] = tg;
      mv[idx] = 1'b1;
      md[idx] = 1'b0;
    end
    exp_rd = mdat[idx][w];
    if (we) begin
      mdat[idx][w] = wd;
      md[idx]      = 1'b1;
    end

    log_q.delete();
    @(negedge clk_i);
    cpu_req_i   = 1'b1;
    cpu_we_i    = we;
    cpu_addr_i  = addr;
    cpu_wdata_i = wd;
    #1;
    if (hit) begin
      check(we ? "R4 hit ack" : "R3 hit ack", 32'(cpu_ack_o), 32'd1);
      check("R3 hit busy", 32'(cpu_busy_o), 32'd0);
      if (!we) check("R3 hit rdata", cpu_rdata_o, exp_rd);
    end else begin
      check("R9 miss busy", 32'(cpu_busy_o), 32'd1);
      check("R9 miss no early ack", 32'(cpu_ack_o), 32'd0);
      cyc = 0;
      while (!cpu_ack_o && cyc < 64) begin
        @(negedge clk_i);
        #1;
        cyc++;
        if (!cpu_ack_o && !cpu_busy_o) check("R9 busy held", 32'd0, 32'd1);
      end
      check(we ? "R6 miss ack" : "R5 miss ack", 32'(cpu_ack_o), 32'd1);
      check("R9 ack busy low", 32'(cpu_busy_o), 32'd0);
      if (!we) check("R5 miss rdata", cpu_rdata_o, exp_rd);
    end
    @(posedge clk_i);
    #1;
    check(wb ? "R8 R7 xfer count" : (hit ? "R4 no traffic" : "R10 xfer count"),
          32'(log_q.size()), 32'(exp_q.size()));
    if (log_q.size() == exp_q.size())
      foreach (exp_q[j]) begin
        check(exp_q[j].we ? "R7 wb dir" : "R5 refill dir", 32'(log_q[j].we), 32'(exp_q[j].we));
        check(exp_q[j].we ? "R2 R7 wb addr" : "R2 R5 refill addr", log_q[j].addr, exp_q[j].addr);
        if (exp_q[j].we) check("R7 R6 wb data", log_q[j].data, exp_q[j].data);
      end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog R9 act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [6:0]  idx_l [4];
    logic [20:0] tag_l [3];
    idx_l = '{7'd0, 7'd1, 7'd5, 7'd127};
    tag_l = '{21'h0, 21'h1, 21'h1F_FFFF};
    repeat (3) @(negedge clk_i);
    check("R1 reset ack", 32'(cpu_ack_o), 32'd0);
    check("R1 reset busy", 32'(cpu_busy_o), 32'd0);
    check("R1 reset mem_req", 32'(mem_req_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle mem_req", 32'(mem_req_o), 32'd0);
    for (int i = 0; i < 240; i++) begin
      logic [31:0] a;
      a = {tag_l[(i * 7) % 3], idx_l[i % 4], 2'((i / 3) % 4), 2'b00};
      access((i % 5) < 2, a, (i * 32'h0101_0101) ^ 32'hC0DE_0000);
    end
    // read back every word touched so dirty data is observed
    for (int t = 0; t < 3; t++)
      for (int l = 0; l < 4; l++)
        for (int w = 0; w < 4; w++)
          access(1'b0, {tag_l[t], idx_l[l], 2'(w), 2'b00}, 32'h0);
    @(negedge clk_i);
    cpu_req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule